// File: doc/BRIEF.md
# Interrupt request routing front-end

This block forms the sixteen request lines that feed a cascaded pair of interrupt controllers. Each line is built from one of several inputs: an external pin, an internal source (the system timer, the floating-point error signal or the pointing-device source), or one of four active-low PCI interrupt lines. A PCI line reaches an IRQ only when a steering register routes it there. A small byte-wide write port holds the four steering registers, the per-line sense selection and a control byte.

Every line ends in its own small state machine, which turns the selected source into a qualified request. In edge mode a rising edge of the source latches a request, and the request holds until the line's clear strobe. In level mode the request is a registered copy of the source. The line machine has three states. `LN_LOW` means the source is low and nothing is latched. `LN_HIGH` means the source is high and nothing is latched. `LN_PEND` means a request is latched.

The transitions of the line machine are as follows:
- `LN_LOW`→`LN_PEND`: rising source in edge mode with no clear.
- `LN_LOW`→`LN_HIGH`: rising source in level mode, or rising source together with a clear.
- `LN_HIGH`→`LN_LOW`: the source falls.
- `LN_PEND`→`LN_LOW` or `LN_HIGH`: a clear or a switch to level mode. The target state depends on the present source level.

Priority resolution and acknowledge are handled downstream.

Top module: `irq_front`

## Requirements
- R1: After reset, every request output is 0, all four steering entries are disabled, every line is in edge mode and the pointing-device select is 0.
- R2: Write address k (0..3) loads the steering entry for PCI line k (A=0 … D=3). When bit 7 of that entry is 0 and bits 3:0 name a legal IRQ, driving that PCI input low asserts the request on the named IRQ. In level mode the request appears one clock later.
- R3: A steering entry has no effect when its bit 7 is 1, or when its target is not one of 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 or 15.
- R4: The line's source is the OR of all PCI inputs steered to the same IRQ (each inverted to active-high) and, where the line has one, its external pin.
- R5: Line 0 is taken from the timer input. External pin 0 is ignored.
- R6: Line 13 is taken from the floating-point error input. External pin 13 is ignored.
- R7: Bit 4 of the control byte (write address 6) selects the source of line 12. A 1 selects the internal pointing-device source and a 0 selects external pin 12.
- R8: Line 2 never asserts a request.
- R9: In edge mode (sense bit 0) a request latches on a rising edge of the source and holds until the line's clear strobe. A clear in the same cycle as a rising edge suppresses the latch. After a clear, a source that stays high does not latch again until it has gone low and then high.
- R10: In level mode (sense bit 1) the request equals the source as sampled at the previous clock edge, and the clear strobe has no effect.
- R11: Write address 4 sets the sense bits of lines 7:0, with bit n controlling line n. Write address 5 sets the sense bits of lines 15:8, with bit n controlling line 8+n. Writes to address 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq | input | 16 | External request pins, active high |
| tmr0_out | input | 1 | System timer output, drives line 0 |
| fpu_err | input | 1 | Floating-point error, drives line 13 |
| mouse_irq | input | 1 | Internal pointing-device request for line 12 |
| pci_int_n | input | 4 | PCI interrupts A..D, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 8 | Register write data |
| req_clr | input | 16 | Per-line clear strobes for latched edge requests |
| irq_req | output | 16 | Qualified request lines |

## Verification
The assertions check several properties on every cycle:
- the quiet outputs right after reset;
- the cascade line, which stays low;
- the timer and floating-point lines, which follow their inputs with one clock of delay in level mode;
- for every line in edge mode, that a latched request holds without a clear and drops after one.

Other behaviour needs the bench's scenarios:
- the steering decode, including disabled and illegal targets and several PCI lines ORed onto one IRQ;
- the pointing-device select;
- the suppressed re-latch after a clear while the source is high;
- the register address map, including the ignored address.

// File: rtl/irq_front_pkg.sv
`timescale 1ns/1ps
package irq_front_pkg;

    // Per-line request state
    typedef enum logic [1:0] {
        LN_LOW  = 2'd0,
        LN_HIGH = 2'd1,
        LN_PEND = 2'd2
    } line_st_e;

    localparam int TGT_W = 4;

    // Stored form of one steering entry: disable flag and target line
    typedef struct packed {
        logic             off;
        logic [TGT_W-1:0] tgt;
    } steer_t;

endpackage

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
module irq_cfg_regs
    import irq_front_pkg::*;
#(
    parameter int NPCI     = 4,
    parameter int NLINE    = 16,
    parameter int AW       = 3,
    parameter int DW       = 8,
    parameter int MSEL_BIT = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output steer_t [NPCI-1:0]     steer_q,
    output logic   [NLINE-1:0]    level_q,
    output logic                  msel_q
);

    localparam int SBYTES     = NLINE / DW;
    localparam int SENSE_BASE = NPCI;
    localparam int CTRL_ADDR  = NPCI + SBYTES;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NPCI; k++) begin
                steer_q[k].off <= 1'b1;
                steer_q[k].tgt <= '0;
            end
            level_q <= '0;
            msel_q  <= 1'b0;
        end else if (we) begin
            for (int k = 0; k < NPCI; k++) begin
                if (addr == AW'(k)) begin
                    steer_q[k].off <= wdata[DW-1];
                    steer_q[k].tgt <= wdata[TGT_W-1:0];
                end
            end
            for (int b = 0; b < SBYTES; b++) begin
                if (addr == AW'(SENSE_BASE + b)) begin
                    level_q[b*DW +: DW] <= wdata;
                end
            end
            if (addr == AW'(CTRL_ADDR)) begin
                msel_q <= wdata[MSEL_BIT];
            end
        end
    end

endmodule

// File: rtl/irq_steer_map.sv
`timescale 1ns/1ps
module irq_steer_map
    import irq_front_pkg::*;
#(
    parameter int               NPCI  = 4,
    parameter int               NLINE = 16,
    parameter logic [NLINE-1:0] LEGAL = 16'hDEF8
) (
    input  steer_t [NPCI-1:0]  steer,
    input  logic   [NPCI-1:0]  pci_n,
    output logic   [NLINE-1:0] hit
);

    // OR of every active PCI line whose entry is enabled and points at a legal line
    always_comb begin
        hit = '0;
        for (int k = 0; k < NPCI; k++) begin
            for (int i = 0; i < NLINE; i++) begin
                if (LEGAL[i] && !steer[k].off &&
                    steer[k].tgt == TGT_W'(i) && !pci_n[k]) begin
                    hit[i] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/irq_src_mux.sv
`timescale 1ns/1ps
module irq_src_mux #(
    parameter int NLINE      = 16,
    parameter int TMR_LINE   = 0,
    parameter int CASC_LINE  = 2,
    parameter int MOUSE_LINE = 12,
    parameter int FPU_LINE   = 13
) (
    input  logic [NLINE-1:0] ext,
    input  logic [NLINE-1:0] hit,
    input  logic             tmr,
    input  logic             fpu,
    input  logic             mouse,
    input  logic             msel,
    output logic [NLINE-1:0] src
);

    for (genvar i = 0; i < NLINE; i++) begin : g_line
        if (i == TMR_LINE) begin : g_tmr
            assign src[i] = tmr;
        end else if (i == CASC_LINE) begin : g_casc
            assign src[i] = 1'b0;
        end else if (i == FPU_LINE) begin : g_fpu
            assign src[i] = fpu;
        end else if (i == MOUSE_LINE) begin : g_mouse
            assign src[i] = (msel ? mouse : ext[i]) | hit[i];
        end else begin : g_pin
            assign src[i] = ext[i] | hit[i];
        end
    end

    // Pins and steering hits that the fixed internal lines do not use
    logic unused_bits;
    assign unused_bits = ^{ext[TMR_LINE], ext[CASC_LINE], ext[FPU_LINE],
                           hit[TMR_LINE], hit[CASC_LINE], hit[FPU_LINE]};

endmodule

// File: rtl/irq_line_sense.sv
`timescale 1ns/1ps
module irq_line_sense
    import irq_front_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic level,
    input  logic clr,
    output logic req
);

    line_st_e st_q, st_d;
    logic     lvl_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LN_LOW;
            lvl_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            lvl_q <= src;
        end
    end

    // Next state and output
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LN_LOW: begin
                if (src && !level && !clr) st_d = LN_PEND;
                else if (src)              st_d = LN_HIGH;
            end
            LN_HIGH: begin
                if (!src) st_d = LN_LOW;
            end
            LN_PEND: begin
                if (level || clr) st_d = src ? LN_HIGH : LN_LOW;
            end
            default: st_d = LN_LOW;
        endcase
        req = level ? lvl_q : (st_q == LN_PEND);
    end

endmodule

// File: rtl/irq_front.sv
`timescale 1ns/1ps
module irq_front
    import irq_front_pkg::*;
#(
    parameter int               NPCI       = 4,
    parameter int               NLINE      = 16,
    parameter int               AW         = 3,
    parameter int               DW         = 8,
    parameter int               MSEL_BIT   = 4,
    parameter int               TMR_LINE   = 0,
    parameter int               CASC_LINE  = 2,
    parameter int               MOUSE_LINE = 12,
    parameter int               FPU_LINE   = 13,
    parameter logic [NLINE-1:0] LEGAL      = 16'hDEF8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLINE-1:0] ext_irq,
    input  logic             tmr0_out,
    input  logic             fpu_err,
    input  logic             mouse_irq,
    input  logic [NPCI-1:0]  pci_int_n,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic [NLINE-1:0] req_clr,
    output logic [NLINE-1:0] irq_req
);

    steer_t [NPCI-1:0]  steer_q;
    logic   [NLINE-1:0] level_q;
    logic               msel_q;
    logic   [NLINE-1:0] hit;
    logic   [NLINE-1:0] src;

    irq_cfg_regs #(
        .NPCI(NPCI), .NLINE(NLINE), .AW(AW), .DW(DW), .MSEL_BIT(MSEL_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .steer_q(steer_q), .level_q(level_q), .msel_q(msel_q)
    );

    irq_steer_map #(
        .NPCI(NPCI), .NLINE(NLINE), .LEGAL(LEGAL)
    ) u_map (
        .steer(steer_q), .pci_n(pci_int_n), .hit(hit)
    );

    irq_src_mux #(
        .NLINE(NLINE), .TMR_LINE(TMR_LINE), .CASC_LINE(CASC_LINE),
        .MOUSE_LINE(MOUSE_LINE), .FPU_LINE(FPU_LINE)
    ) u_mux (
        .ext(ext_irq), .hit(hit), .tmr(tmr0_out), .fpu(fpu_err),
        .mouse(mouse_irq), .msel(msel_q), .src(src)
    );

    for (genvar i = 0; i < NLINE; i++) begin : g_sense
        irq_line_sense u_line (
            .clk(clk), .rst_n(rst_n), .src(src[i]), .level(level_q[i]),
            .clr(req_clr[i]), .req(irq_req[i])
        );
    end

endmodule

// File: rtl/irq_front_chk.sv
`timescale 1ns/1ps
module irq_front_chk #(
    parameter int NLINE     = 16,
    parameter int TMR_LINE  = 0,
    parameter int CASC_LINE = 2,
    parameter int FPU_LINE  = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr0_out,
    input logic             fpu_err,
    input logic [NLINE-1:0] req_clr,
    input logic [NLINE-1:0] level_q,
    input logic [NLINE-1:0] irq_req
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !past_ok |-> irq_req == '0);

    p_cascade_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[CASC_LINE] == 1'b0);

    p_timer_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && level_q[TMR_LINE] |-> irq_req[TMR_LINE] == $past(tmr0_out));

    p_fpu_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && level_q[FPU_LINE] |-> irq_req[FPU_LINE] == $past(fpu_err));

    for (genvar i = 0; i < NLINE; i++) begin : g_edge
        p_edge_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && !level_q[i] && !$past(level_q[i]) && $past(irq_req[i]) &&
            !$past(req_clr[i]) |-> irq_req[i]);

        p_edge_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && !level_q[i] && !$past(level_q[i]) && $past(req_clr[i])
            |-> !irq_req[i]);
    end

endmodule

bind irq_front irq_front_chk #(
    .NLINE(NLINE), .TMR_LINE(TMR_LINE), .CASC_LINE(CASC_LINE), .FPU_LINE(FPU_LINE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tmr0_out(tmr0_out), .fpu_err(fpu_err),
    .req_clr(req_clr), .level_q(level_q), .irq_req(irq_req)
);

// File: tb/irq_front_bench.sv
`timescale 1ns/1ps
module irq_front_bench;

    typedef struct packed {
        logic [7:0]  sa, sb, sc, sd;
        logic        msel;
        logic [3:0]  pn;
        logic [15:0] ext;
        logic        tmr, fpu, mou;
        logic [15:0] exp;
    } vec_t;

    // All lines in level mode while these run
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h80, 8'h80, 8'h80, 8'h80, 1'b0, 4'hF, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R3 idle
        '{8'h05, 8'h80, 8'h80, 8'h80, 1'b0, 4'hE, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0020}, // R2 A->5
        '{8'h05, 8'h05, 8'h80, 8'h80, 1'b0, 4'hC, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0020}, // R4 A,B->5
        '{8'h8A, 8'h80, 8'h80, 8'h80, 1'b0, 4'hE, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R3 bit7
        '{8'h02, 8'h0D, 8'h00, 8'h08, 1'b0, 4'h0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R3 illegal
        '{8'h80, 8'h80, 8'h80, 8'h80, 1'b0, 4'hF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 16'hDFFA}, // R5 R6 R8 pins
        '{8'h80, 8'h80, 8'h80, 8'h80, 1'b0, 4'hF, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h2001}, // R5 R6 internal
        '{8'h80, 8'h80, 8'h80, 8'h80, 1'b1, 4'hF, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h1000}, // R7 mouse
        '{8'h80, 8'h80, 8'h80, 8'h80, 1'b1, 4'hF, 16'h1000, 1'b0, 1'b0, 1'b0, 16'h0000}, // R7 pin ignored
        '{8'h80, 8'h80, 8'h80, 8'h80, 1'b0, 4'hF, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0000}, // R7 mouse ignored
        '{8'h80, 8'h80, 8'h0F, 8'h03, 1'b0, 4'h3, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h8008}, // R2 R11 C,D
        '{8'h0C, 8'h80, 8'h80, 8'h80, 1'b0, 4'hE, 16'h0010, 1'b0, 1'b0, 1'b0, 16'h1010}  // R4 with pin
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ext_irq = '0;
    logic        tmr0_out = 1'b0, fpu_err = 1'b0, mouse_irq = 1'b0;
    logic [3:0]  pci_int_n = 4'hF;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] req_clr = '0;
    logic [15:0] irq_req;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_front u_irq_front (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .tmr0_out(tmr0_out),
        .fpu_err(fpu_err), .mouse_irq(mouse_irq), .pci_int_n(pci_int_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .req_clr(req_clr), .irq_req(irq_req)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic check(input string req, input logic [15:0] exp);
        n_chk++;
        if (irq_req !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_req actual %h expected %h", req, irq_req, exp);
        end
    endtask

    initial begin
        #(8 * 50000);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset outputs", 16'h0000);

        // R1 edge default, R9 latch and hold
        ext_irq[3] = 1'b1; tick(); check("R9 edge latch", 16'h0008);
        ext_irq[3] = 1'b0; tick(); check("R1 R9 edge hold", 16'h0008);
        req_clr[3] = 1'b1; tick(); req_clr = '0; check("R9 clear", 16'h0000);

        // R9 no re-latch while source stays high
        ext_irq[5] = 1'b1; tick(); check("R9 latch line5", 16'h0020);
        req_clr[5] = 1'b1; tick(); req_clr = '0; check("R9 clear high", 16'h0000);
        tick(); check("R9 no relatch", 16'h0000);
        ext_irq[5] = 1'b0; tick();
        ext_irq[5] = 1'b1; tick(); check("R9 new edge", 16'h0020);
        ext_irq[5] = 1'b0; req_clr[5] = 1'b1; tick(); req_clr = '0;
        check("R9 clear low", 16'h0000);

        // R9 clear and rise together
        ext_irq[6] = 1'b1; req_clr[6] = 1'b1; tick(); req_clr = '0;
        check("R9 clear wins", 16'h0000);
        tick(); check("R9 clear wins hold", 16'h0000);
        ext_irq[6] = 1'b0; tick();

        // Level mode for the table
        wr(3'd4, 8'hFF);
        wr(3'd5, 8'hFF);
        for (int v = 0; v < NV; v++) begin
            wr(3'd0, VECS[v].sa);
            wr(3'd1, VECS[v].sb);
            wr(3'd2, VECS[v].sc);
            wr(3'd3, VECS[v].sd);
            wr(3'd6, {3'b000, VECS[v].msel, 4'h0});
            pci_int_n = VECS[v].pn; ext_irq = VECS[v].ext;
            tmr0_out = VECS[v].tmr; fpu_err = VECS[v].fpu; mouse_irq = VECS[v].mou;
            tick();
            check($sformatf("vector %0d (R2 R3 R4 R5 R6 R7 R8)", v), VECS[v].exp);
        end
        ext_irq = '0; pci_int_n = 4'hF; tmr0_out = 1'b0; fpu_err = 1'b0; mouse_irq = 1'b0;
        tick(); check("R10 level drop", 16'h0000);

        // R10 level follows, clear ignored
        ext_irq[4] = 1'b1; tick(); check("R10 level high", 16'h0010);
        req_clr[4] = 1'b1; tick(); req_clr = '0; check("R10 clear ignored", 16'h0010);
        ext_irq[4] = 1'b0; tick(); check("R10 level low", 16'h0000);

        // R11 high sense byte maps bit 6 to line 14
        wr(3'd5, 8'h00);
        ext_irq[14] = 1'b1; tick();
        ext_irq[14] = 1'b0; tick(); check("R11 line14 edge", 16'h4000);
        wr(3'd5, 8'h40); check("R11 line14 level", 16'h0000);
        wr(3'd5, 8'hFF);

        // R11 address 7 ignored
        wr(3'd7, 8'hFF);
        mouse_irq = 1'b1; tick(); check("R11 addr7 ctrl kept", 16'h0000);
        mouse_irq = 1'b0; pci_int_n = 4'hE; tick(); check("R11 addr7 steer kept", 16'h1000);
        pci_int_n = 4'hF; tick();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule